// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one read burst inside a memory page whose columns are selected by an 8-bit address. When a start strobe arrives it captures a starting column, a burst length code and an ordering bit. From the next clock on it presents one column per cycle with a valid flag, and it raises a last flag on the final beat.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned group of columns whose size equals the burst length. The low column bits are the starting offset within that group, and the offset wraps inside the group. Two orderings are available. In linear order, beat n sits at offset (start + n) mod length. In interleaved order, beat n sits at offset start XOR n. A full-page burst walks the whole page in linear order, wraps from the top column back to column 0, and only ends when the terminate strobe is applied. This gives bursts of any length.

A burst controller drives the block once per read command. It forwards the columns to the array and uses the last flag to free the data path. Codes that the block does not support are refused with a one-cycle error pulse, and no beats follow.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `valid_o`, `last_o` and `err_o` are low, and they stay low until a start strobe arrives.
- R2: When `start_i` is sampled high with a supported code, the cycle after that edge shows `valid_o` high and `col_o` equal to the sampled `start_col_i`.
- R3: With `order_i` = 0 (linear) and a fixed length BL, beat n shows column `(start & ~(BL-1)) | ((start + n) mod BL)`. The column bits above the offset never change during a burst.
- R4: With `order_i` = 1 (interleaved) and a fixed length BL, beat n shows column `(start & ~(BL-1)) | ((start mod BL) XOR n)`.
- R5: `len_code_i` values 0, 1, 2 and 3 give exactly 1, 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` is low in the cycle after it unless a new start is sampled.
- R6: `len_code_i` = 7 with `order_i` = 0 selects a full-page burst. Each beat's column is the previous column plus one modulo 256, so column 255 is followed by column 0. The burst runs for as long as no terminate is sampled.
- R7: In a full-page burst, `term_i` sampled high at an edge makes the beat shown after that edge carry `last_o`, and `valid_o` drops in the cycle after that beat.
- R8: `term_i` has no effect on a fixed-length burst. The full beat sequence of R3 or R4 is produced.
- R9: A start with `len_code_i` of 4, 5 or 6, or with code 7 together with `order_i` = 1, raises `err_o` for exactly the following cycle. No beat is produced and any running burst is ended.
- R10: A start sampled during a running burst abandons that burst. The new burst's first beat appears in the next cycle.
- R11: `last_o` is never high while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle per burst |
| start_col_i | input | COL_W | Starting column, sampled with the start |
| len_code_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=full page, others refused |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| term_i | input | 1 | Terminate strobe for full-page bursts |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final one |
| err_o | output | 1 | The previous start carried a refused code |

## Verification
The bench builds the block with the default COL_W of 8, so a page has 256 columns. At that width a full-page burst can cross the 255-to-0 wrap within a few hundred cycles, and random starting columns reach every alignment of the 2-, 4- and 8-beat groups. Random bursts mix both orders and all supported lengths with terminate points spread across the page. Directed cases cover aborting a running burst, refused codes arriving mid-burst, and a terminate held high through a fixed burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned LOG_LEN_W  = 4;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_RSV4 = 3'd4,
    LEN_RSV5 = 3'd5,
    LEN_RSV6 = 3'd6,
    LEN_PAGE = 3'd7
  } len_code_e;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // log2 of the beat count for the fixed lengths, 0 for anything else
  function automatic logic [LOG_LEN_W-1:0] log_len(input len_code_e code);
    case (code)
      LEN_2:   log_len = LOG_LEN_W'(1);
      LEN_4:   log_len = LOG_LEN_W'(2);
      LEN_8:   log_len = LOG_LEN_W'(3);
      default: log_len = '0;
    endcase
  endfunction

  // a code is accepted for the given order
  function automatic logic code_accepted(input len_code_e code, input order_e ord);
    case (code)
      LEN_1, LEN_2, LEN_4, LEN_8: code_accepted = 1'b1;
      LEN_PAGE:                   code_accepted = (ord == ORD_LINEAR);
      default:                    code_accepted = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int unsigned COL_W = 8
) (
  input  logic [burst_pkg::LEN_CODE_W-1:0] code_i,
  input  logic                             order_i,
  output logic [COL_W-1:0]                 mask_o,
  output logic                             page_o,
  output logic                             ok_o
);
  import burst_pkg::*;

  len_code_e             code;
  order_e                ord;
  logic [LOG_LEN_W-1:0]  lg;

  assign code   = len_code_e'(code_i);
  assign ord    = order_e'(order_i);
  assign lg     = log_len(code);
  assign page_o = (code == LEN_PAGE);
  assign ok_o   = code_accepted(code, ord);

  // one mask bit per column bit: set below the group boundary
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = page_o | (lg > LOG_LEN_W'(i));
  end

endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             order_i,
  output logic [COL_W-1:0] col_o
);

  // offset inside the aligned group for beat n
  function automatic logic [COL_W-1:0] group_offset(
    input logic [COL_W-1:0] start,
    input logic [COL_W-1:0] n,
    input logic [COL_W-1:0] mask,
    input logic             use_xor
  );
    logic [COL_W-1:0] first;
    first = start & mask;
    if (use_xor) group_offset = (first ^ n) & mask;
    else         group_offset = (first + n) & mask;
  endfunction

  assign col_o = (start_i & ~mask_i) | group_offset(start_i, beat_i, mask_i, order_i);

endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             code_ok_i,
  input  logic             page_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             order_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             order_o,
  output logic             page_o,
  output logic             last_o,
  output logic             err_o,
  output logic             term_take_o
);

  logic term_seen;

  assign last_o      = active_o & (page_o ? term_seen : (beat_o == mask_o));
  assign term_take_o = term_i & active_o & page_o & ~term_seen & ~start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      beat_o    <= '0;
      base_o    <= '0;
      mask_o    <= '0;
      order_o   <= 1'b0;
      page_o    <= 1'b0;
      term_seen <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      err_o <= start_i & ~code_ok_i;
      if (start_i) begin
        active_o  <= code_ok_i;
        beat_o    <= '0;
        base_o    <= start_col_i;
        mask_o    <= mask_i;
        order_o   <= order_i;
        page_o    <= page_i;
        term_seen <= 1'b0;
      end else if (active_o) begin
        if (last_o) begin
          active_o  <= 1'b0;
          term_seen <= 1'b0;
        end else begin
          beat_o <= beat_o + 1'b1;
          if (term_take_o) term_seen <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [COL_W-1:0]                 start_col_i,
  input  logic [burst_pkg::LEN_CODE_W-1:0] len_code_i,
  input  logic                             order_i,
  input  logic                             term_i,
  output logic [COL_W-1:0]                 col_o,
  output logic                             valid_o,
  output logic                             last_o,
  output logic                             err_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             start_ok;
  logic             running;
  logic [COL_W-1:0] beat_idx;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] blk_mask;
  logic             run_order;
  logic             full_burst;
  logic             term_take;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i  (len_code_i),
    .order_i (order_i),
    .mask_o  (dec_mask),
    .page_o  (dec_page),
    .ok_o    (start_ok)
  );

  burst_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .code_ok_i   (start_ok),
    .page_i      (dec_page),
    .mask_i      (dec_mask),
    .order_i     (order_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .active_o    (running),
    .beat_o      (beat_idx),
    .base_o      (base_col),
    .mask_o      (blk_mask),
    .order_o     (run_order),
    .page_o      (full_burst),
    .last_o      (last_o),
    .err_o       (err_o),
    .term_take_o (term_take)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .start_i (base_col),
    .beat_i  (beat_idx),
    .mask_i  (blk_mask),
    .order_i (run_order),
    .col_o   (col_o)
  );

  assign valid_o = running;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o,
  input logic             start_ok,
  input logic [COL_W-1:0] blk_mask,
  input logic             full_burst,
  input logic             term_take
);

  // R11
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && start_ok) |=> (valid_o && col_o == $past(start_col_i)));

  // R9
  refused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !start_ok) |=> (err_o && !valid_o));

  // R5
  stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  // R3
  stay_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i) |=>
      ((col_o & ~blk_mask) == ($past(col_o) & ~$past(blk_mask))));

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i && full_burst) |=>
      (col_o == COL_W'($past(col_o) + 1'b1)));

  // R7
  term_ends_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && valid_o && full_burst && !last_o && !start_i) |=> last_o);

  // R7
  term_take_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_take |-> (full_burst && valid_o));

  // R8
  fixed_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !full_burst && !last_o && !start_i) |=> valid_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .err_o       (err_o),
  .start_ok    (start_ok),
  .blk_mask    (blk_mask),
  .full_burst  (full_burst),
  .term_take   (term_take)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;

  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             order_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             err_o;

  int vectors = 0;
  int miscompares = 0;
  bit term_force = 0;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_i(order_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int beats_of(input int code);
    return (code == 7) ? 0 : (1 << code);
  endfunction

  // expected column, restated arithmetically
  function automatic int want_col(input int s, input int n, input int code, input int ord);
    int bl, grp, off;
    if (code == 7) return (s + n) % PAGE;
    bl  = beats_of(code);
    grp = s - (s % bl);
    off = ord ? ((s % bl) ^ n) : (((s % bl) + n) % bl);
    return grp + off;
  endfunction

  task automatic issue(input int s, input int code, input int ord);
    start_col_i = COL_W'(s);
    len_code_i  = 3'(code);
    order_i     = ord[0];
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
  endtask

  // checks beats; stop_after > 0 returns with that many beats seen
  task automatic follow(input int s, input int code, input int ord,
                        input int term_at, input int stop_after, input string req);
    int nb;
    nb = (code == 7) ? term_at + 2 : beats_of(code);
    for (int b = 0; b < nb; b++) begin
      check({req, " valid"}, int'(valid_o), 1);
      check({req, " col"}, int'(col_o), want_col(s, b, code, ord));
      check({req, " last"}, int'(last_o), int'(b == nb - 1));
      term_i = term_force || (code == 7 && b == term_at);
      if (b == stop_after - 1) return;
      @(negedge clk);
      term_i = 1'b0;
    end
    term_i = 1'b0;
    check({req, " end valid"}, int'(valid_o), 0);
    check({req, " end last"}, int'(last_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0c01;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(valid_o), 0);
    check("R1 last", int'(last_o), 0);
    check("R1 err", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", int'(valid_o), 0);

    // R3 R5 linear wrap inside group of 8
    issue(8'h3D, 3, 0);  follow(8'h3D, 3, 0, 0, -1, "R3");
    // R4 interleaved order
    issue(8'h96, 3, 1);  follow(8'h96, 3, 1, 0, -1, "R4");
    issue(8'h03, 2, 1);  follow(8'h03, 2, 1, 0, -1, "R4");
    // R5 each length
    issue(8'h7F, 0, 0);  follow(8'h7F, 0, 0, 0, -1, "R5");
    issue(8'h11, 1, 0);  follow(8'h11, 1, 0, 0, -1, "R5");
    issue(8'h06, 2, 0);  follow(8'h06, 2, 0, 0, -1, "R5");
    // R6 R7 full page across the 255->0 wrap
    issue(8'hFC, 7, 0);  follow(8'hFC, 7, 0, 6, -1, "R6");
    issue(8'h20, 7, 0);  follow(8'h20, 7, 0, 0, -1, "R7");
    issue(8'h00, 7, 0);  follow(8'h00, 7, 0, 300, -1, "R6");
    // R8 terminate held through fixed bursts
    term_force = 1;
    issue(8'h45, 2, 0);  follow(8'h45, 2, 0, 0, -1, "R8");
    issue(8'hE9, 3, 1);  follow(8'hE9, 3, 1, 0, -1, "R8");
    term_force = 0;
    // R10 abort a running burst
    issue(8'h35, 3, 0);  follow(8'h35, 3, 0, 0, 3, "R10");
    issue(8'hA2, 2, 1);  follow(8'hA2, 2, 1, 0, -1, "R10");
    issue(8'h10, 7, 0);  follow(8'h10, 7, 0, 0, 5, "R10");
    issue(8'h5B, 1, 0);  follow(8'h5B, 1, 0, 0, -1, "R10");
    // R9 refused codes, idle and mid-burst
    for (int c = 4; c <= 7; c++) begin
      issue(8'h12, c, (c == 7) ? 1 : 0);
      check("R9 err", int'(err_o), 1);
      check("R9 valid", int'(valid_o), 0);
      @(negedge clk);
      check("R9 err drop", int'(err_o), 0);
      check("R9 no beats", int'(valid_o), 0);
    end
    issue(8'h40, 3, 0);  follow(8'h40, 3, 0, 0, 2, "R9");
    issue(8'h40, 7, 1);
    check("R9 err mid", int'(err_o), 1);
    check("R9 ends burst", int'(valid_o), 0);
    @(negedge clk);
    check("R9 stays idle", int'(valid_o), 0);

    // random bursts
    for (int k = 0; k < 300; k++) begin
      int s, code, ord, tat;
      s    = int'($urandom_range(PAGE - 1, 0));
      code = int'($urandom_range(4, 0));
      if (code == 4) begin
        code = 7; ord = 0;
      end else begin
        ord = int'($urandom_range(1, 0));
      end
      tat = int'($urandom_range(299, 0));
      issue(s, code, ord);
      follow(s, code, ord, tat, -1, ord ? "R4 rnd" : "R3 rnd");
      if ($urandom_range(3, 0) == 0) @(negedge clk);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule